// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns the system clock into a one-clock enable pulse at sixteen times the serial bit rate. The divisor has a 16-bit whole part and a 6-bit fractional part. The fractional part is spread over the tick periods by a small phase accumulator, so that some periods are one clock longer than others and the mean period matches the programmed ratio.

Software programs the divisor in three steps. It writes the whole part and the fractional part into holding registers, and those writes alone change nothing. A line-control write then copies both holding values into a pending slot. The pending value moves into the working divisor only when the serial engines report a character boundary, meaning the line is idle or a character has just ended. As a result, a character that is already on the wire always finishes at the rate it started with.

All of these interfaces are plain control pins. Nothing here flows as a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the holding, pending and working divisors are all zero and `tick` is low. A line-control write followed by a boundary, with no divisor writes in between, keeps the generator silent.
- R2: `int_wr` loads `wr_data[15:0]` into the whole-part holding register, and `frac_wr` loads `wr_data[5:0]` into the fraction holding register. Neither write changes the tick spacing.
- R3: `lcr_wr` copies the holding registers into the pending slot. Holding writes made after that copy do not alter the value that is later applied.
- R4: A pending divisor is applied only in a cycle where `char_bnd` is high. Until then the previous spacing continues.
- R5: With a whole part I ≥ 1, every tick period is I or I+1 clocks long, and it is exactly I clocks when the fraction is zero.
- R6: Over any 64 consecutive tick periods the total length is exactly 64·I + F clocks, where F is the fraction.
- R7: A working whole part of zero produces no ticks.
- R8: With I ≥ 2, `tick` is high for exactly one clock per period.
- R9: Applying a divisor clears the accumulator and restarts the period. The first tick under the new divisor comes I+1 clocks after the applying edge, counting the clock in which the tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_wr | input | 1 | Write strobe for the whole-part holding register |
| frac_wr | input | 1 | Write strobe for the fraction holding register |
| lcr_wr | input | 1 | Line-control write; stages the holding divisor |
| wr_data | input | 16 | Write data shared by both divisor strobes |
| char_bnd | input | 1 | High when the serial engines are idle or at the end of a character |
| tick | output | 1 | Oversampling enable pulse |

## Verification
Most internal faults show up as a change in tick spacing. A wrong accumulator or a wrong carry shifts the 64-period total away from 64·I+F within a single measurement window. A counter that runs one clock past its limit shows up as a period outside {I, I+1} at the next tick. A staging fault shows up as the spacing changing too early: a pending value that leaks past a low `char_bnd`, or a holding write that changes the working divisor, alters the next period measured. A missing restart on apply shows up as the wrong latency to the first tick after the commit.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 6;
  localparam int CNT_W  = INT_W + 1;

  typedef struct packed {
    logic [INT_W-1:0]  ip;
    logic [FRAC_W-1:0] fp;
  } div_t;
endpackage

// File: rtl/baud_stage.sv
module baud_stage
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_wr,
  input  logic             frac_wr,
  input  logic             lcr_wr,
  input  logic [INT_W-1:0] wr_data,
  input  logic             char_bnd,
  output div_t             work,
  output logic             apply
);
  div_t hold_q, pend_q, work_q;
  logic pend_vld_q;

  assign apply = pend_vld_q & char_bnd;
  assign work  = work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      pend_q     <= '0;
      work_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (int_wr)  hold_q.ip <= wr_data;
      if (frac_wr) hold_q.fp <= wr_data[FRAC_W-1:0];
      if (lcr_wr) begin
        pend_q     <= hold_q;
        pend_vld_q <= 1'b1;
      end else if (apply) begin
        pend_vld_q <= 1'b0;
      end
      if (apply) work_q <= pend_q;
    end
  end

  // R2 / R4: working divisor moves only on an apply
  assert_work_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(work_q));
  // R4: no pending commit appears without a line-control write
  assert_pend_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_vld_q && !lcr_wr) |=> !pend_vld_q);
  // R3: the pending slot keeps its snapshot until the next line-control write
  assert_pend_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> $stable(pend_q));
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] frac,
  input  logic              clr,
  input  logic              step,
  output logic              ext
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac};
  assign ext = sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (step) acc_q <= sum[FRAC_W-1:0];
  end

  // R9: an apply leaves the accumulator at zero
  assert_acc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
  // R6: the accumulator only moves at a period end
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(acc_q));
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] ip,
  input  logic             ext,
  input  logic             restart,
  output logic             last,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             run;
  logic             tick_q;

  assign run   = (ip != '0);
  assign limit = {1'b0, ip} + CNT_W'(ext) - CNT_W'(1);
  assign last  = run && (cnt_q == limit);
  assign tick  = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= last;
      if (restart || !run || last) cnt_q <= '0;
      else                         cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R5: the count never runs past the longest allowed period
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= {1'b0, ip}));
  // R7: a zero whole part yields no tick
  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick_q);
  // R8: with a period of two or more, period ends never come back to back
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !restart && ip >= INT_W'(2)) |=> !last);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        int_wr,
  input  logic        frac_wr,
  input  logic        lcr_wr,
  input  logic [15:0] wr_data,
  input  logic        char_bnd,
  output logic        tick
);
  div_t work;
  logic apply;
  logic ext;
  logic last;

  baud_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_wr   (int_wr),
    .frac_wr  (frac_wr),
    .lcr_wr   (lcr_wr),
    .wr_data  (wr_data),
    .char_bnd (char_bnd),
    .work     (work),
    .apply    (apply)
  );

  baud_frac_acc u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .frac  (work.fp),
    .clr   (apply),
    .step  (last),
    .ext   (ext)
  );

  baud_period_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ip      (work.ip),
    .ext     (ext),
    .restart (apply),
    .last    (last),
    .tick    (tick)
  );
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {16'd4, 6'd0}, {16'd4, 6'd1}, {16'd5, 6'd32},
    {16'd3, 6'd63}, {16'd9, 6'd21}, {16'd2, 6'd47}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_wr = 1'b0, frac_wr = 1'b0, lcr_wr = 1'b0, char_bnd = 1'b0;
  logic [15:0] wr_data = '0;
  logic tick;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .int_wr(int_wr), .frac_wr(frac_wr),
    .lcr_wr(lcr_wr), .wr_data(wr_data), .char_bnd(char_bnd), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe_int(input int v);
    @(negedge clk); int_wr = 1'b1; wr_data = 16'(v);
    @(negedge clk); int_wr = 1'b0;
  endtask
  task automatic strobe_frac(input int v);
    @(negedge clk); frac_wr = 1'b1; wr_data = 16'(v);
    @(negedge clk); frac_wr = 1'b0;
  endtask
  task automatic strobe_lcr();
    @(negedge clk); lcr_wr = 1'b1;
    @(negedge clk); lcr_wr = 1'b0;
  endtask
  task automatic pulse_bnd();
    @(negedge clk); char_bnd = 1'b1;
    @(negedge clk); char_bnd = 1'b0;
  endtask
  task automatic program_div(input int i, input int f);
    strobe_int(i); strobe_frac(f); strobe_lcr(); pulse_bnd();
  endtask

  // total clocks over n periods, starting at a tick; also min/max period
  task automatic measure(input int n, output int total, output int mn, output int mx);
    int c = 0, seen = 0, guard = 0;
    total = 0; mn = 1 << 30; mx = 0;
    while (!tick && guard < 5000) begin @(negedge clk); guard++; end
    while (seen < n && guard < 50000) begin
      @(negedge clk); guard++; c++;
      if (tick) begin
        total += c; seen++;
        if (c < mn) mn = c;
        if (c > mx) mx = c;
        c = 0;
      end
    end
    if (seen < n) total = -1;
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin @(negedge clk); if (tick) n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tot, mn, mx, n, k;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
    count_ticks(200, n);
    chk(n == 0, "R1/R7 silent after reset", n, 0);

    // table walk: spacing under several divisors
    for (int v = 0; v < NV; v++) begin
      int iv = int'(VEC[v][21:6]);
      int fv = int'(VEC[v][5:0]);
      program_div(iv, fv);
      measure(64, tot, mn, mx);
      chk(tot == 64*iv + fv, "R6 64-period total", tot, 64*iv + fv);
      chk(mn >= iv && mx <= iv + ((fv != 0) ? 1 : 0), "R5 period range", mx, iv);
    end

    // R9: first tick after apply
    strobe_int(7); strobe_frac(0); strobe_lcr();
    @(negedge clk); char_bnd = 1'b1;
    @(posedge clk);
    @(negedge clk); char_bnd = 1'b0;
    k = 1;
    while (k < 100) begin
      @(negedge clk); k++;
      if (tick) break;
    end
    chk(k == 8, "R9 first tick latency", k, 8);

    // R2: holding writes plus a boundary change nothing
    strobe_int(3); strobe_frac(10); pulse_bnd();
    measure(8, tot, mn, mx);
    chk(tot == 56, "R2 holding writes ignored", tot, 56);

    // R4: staged but no boundary yet
    strobe_lcr();
    measure(8, tot, mn, mx);
    chk(tot == 56, "R4 deferred until boundary", tot, 56);
    pulse_bnd();
    measure(64, tot, mn, mx);
    chk(tot == 64*3 + 10, "R4 applied at boundary", tot, 202);

    // R3: snapshot taken at line-control write
    strobe_int(5); strobe_frac(0); strobe_lcr();
    strobe_int(11); strobe_frac(40);
    pulse_bnd();
    measure(64, tot, mn, mx);
    chk(tot == 320, "R3 snapshot preserved", tot, 320);

    // R8: one-clock pulse at I=5
    while (!tick) @(negedge clk);
    @(negedge clk);
    chk(tick == 1'b0, "R8 single-cycle tick", int'(tick), 0);

    // R7: zero whole part
    program_div(0, 0);
    repeat (3) @(negedge clk);
    count_ticks(300, n);
    chk(n == 0, "R7 zero divisor silent", n, 0);

    // R1: reset mid-run clears everything
    program_div(4, 0);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tick == 1'b0, "R1 tick cleared by reset", int'(tick), 0);
    rst_n = 1'b1;
    count_ticks(200, n);
    chk(n == 0, "R1 working cleared", n, 0);
    strobe_lcr(); pulse_bnd();
    count_ticks(200, n);
    chk(n == 0, "R1 holding cleared", n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule